// File: doc/BRIEF.md
# Management Port Receive Frame Buffer

This block sits behind a small receive MAC on a management Ethernet port and holds exactly one received frame until a host CPU has collected it. The port has no DMA, so the host moves the frame itself: it reads a 32-bit control/status word to learn the frame length and its error flags. It then pulls the payload one 32-bit word per read from a single data address. Finally it writes the control address to hand the buffer back to hardware.

Bytes arrive on a byte-wide stream with a valid strobe, an end-of-frame marker and two error flags (receive error and CRC error) supplied by the upstream MAC. Bytes are packed big-endian into 32-bit words and stored. When the final byte lands, the block marks the buffer ready, records a pending receive-ready cause and, if that cause is enabled, raises its interrupt line. Until the host acknowledges, incoming traffic is discarded and counted internally. Frames flagged with errors are stored like good ones, so the host must drain them before acknowledging.

Top module: `mgmt_rx_buffer`

## Requirements
- R1: After reset the control word, interrupt-enable word and interrupt-cause word all read zero and `rx_irq` is low.
- R2: The control word at offset 0x810 has bit 15 = frame ready, bit 14 = receive error, bit 13 = CRC error, bits 12:11 = 0, bits 10:0 = frame length in bytes, and bits 31:16 = 0. The ready bit rises only on the clock edge that accepts the last byte of a frame.
- R3: Each read of the data word at offset 0x818 returns the next word of the frame. A frame of N bytes yields ceil(N/4) words. The first byte is in bits 31:24, the following bytes are in the next lower lanes, and unused lanes of the final word are zero.
- R4: A data read past the final word, or any data read while no frame is ready, returns zero and does not move the read position.
- R5: A frame with the receive-error input on any of its bytes, or the CRC-error input on its last byte, is still stored in full, and its length and the matching flag are reported.
- R6: A write to the control word with bit 15 = 0 acknowledges the frame: the control word reads zero, the read position returns to the first word and the receive-ready cause clears. A control write with bit 15 = 1 changes nothing.
- R7: Bytes arriving while the ready bit is set are dropped and counted in an internal overflow counter, and the stored frame stays intact. A frame whose first byte is dropped is dropped to its last byte, even if the acknowledgement arrives mid-frame.
- R8: A frame longer than 2047 bytes keeps its first 2047 bytes, reports length 2047 and sets the receive-error bit.
- R9: The interrupt-enable word at 0x8C0 and the cause word at 0x8C4 use bit 0 for receive-ready and bit 1 for transmit-done. Transmit-done always reads 0 here. Cause bit 0 becomes pending when a frame completes, and `rx_irq` is high exactly while cause bit 0 and enable bit 0 are both 1.
- R10: Read data appears on `host_rdata` the clock after the read request, and reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte_vld | input | 1 | Receive byte strobe |
| rx_byte | input | 8 | Receive byte |
| rx_byte_last | input | 1 | Marks the last byte of a frame |
| rx_bad | input | 1 | Receive error reported by the MAC for this byte |
| rx_fcs_bad | input | 1 | CRC failure, meaningful on the last byte |
| host_req | input | 1 | Host register access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Register byte offset |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, valid the cycle after a read |
| rx_irq | output | 1 | Receive-ready interrupt |

## Verification
The checker watches the invariants on every cycle. The ready bit never rises without a completed frame and never falls without an acknowledgement. No word is written while a frame is held. Every byte offered during that time bumps the overflow counter. The read position stays within the frame, and the interrupt never fires without a held frame. What only the bench's scenarios can show is the content: big-endian lane order and zero padding of the last word, length and flag values for random and truncated frames, the ignored control write, and the whole-frame discard when the acknowledgement lands mid-frame.

// File: rtl/mgmt_rx_pkg.sv
package mgmt_rx_pkg;
  localparam int unsigned HOST_AW = 12;
  localparam int unsigned HOST_DW = 32;

  // register offsets decoded by the host driver
  localparam logic [HOST_AW-1:0] OFS_RXCTL  = 12'h810;
  localparam logic [HOST_AW-1:0] OFS_RXDAT  = 12'h818;
  localparam logic [HOST_AW-1:0] OFS_IEN    = 12'h8C0;
  localparam logic [HOST_AW-1:0] OFS_ICAUSE = 12'h8C4;

  // control word field positions
  localparam int unsigned BIT_RDY = 15;
  localparam int unsigned BIT_ERR = 14;
  localparam int unsigned BIT_CRC = 13;

  // interrupt word bit positions
  localparam int unsigned IRQ_RX = 0;
endpackage

// File: rtl/rxb_fill.sv
module rxb_fill #(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned OVF_W = 16,
  localparam int unsigned WA_W = LEN_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [7:0]       in_byte,
  input  logic             in_last,
  input  logic             in_err,
  input  logic             in_crc,
  input  logic             hold_i,
  output logic             wr_en,
  output logic [WA_W-1:0]  wr_addr,
  output logic [31:0]      wr_word,
  output logic             done_o,
  output logic [LEN_W-1:0] done_len,
  output logic             done_err,
  output logic             done_crc,
  output logic [OVF_W-1:0] ovf_cnt
);
  localparam logic [LEN_W-1:0] CAP    = '1;
  localparam logic [LEN_W-1:0] CAP_M1 = CAP - 1'b1;

  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic [31:0]      word_q, word_n;
  logic             err_q, err_n, crc_q, crc_n, skip_q, skip_n;
  logic [OVF_W-1:0] ovf_q, ovf_n;
  logic             take, lose, room;

  always_comb begin
    take     = in_vld & ~hold_i & ~skip_q;
    lose     = in_vld & (hold_i | skip_q);
    room     = (cnt_q != CAP);
    cnt_n    = cnt_q;
    word_n   = word_q;
    err_n    = err_q;
    crc_n    = crc_q;
    skip_n   = skip_q;
    ovf_n    = ovf_q;
    wr_en    = 1'b0;
    done_o   = 1'b0;
    done_len = cnt_q;
    done_err = 1'b0;
    done_crc = 1'b0;
    if (take) begin
      if (room) begin
        case (cnt_q[1:0])
          2'd0:    word_n = {in_byte, 24'h0};
          2'd1:    word_n[23:16] = in_byte;
          2'd2:    word_n[15:8]  = in_byte;
          default: word_n[7:0]   = in_byte;
        endcase
        cnt_n = cnt_q + 1'b1;
        wr_en = (cnt_q[1:0] == 2'd3) | in_last | (cnt_q == CAP_M1);
      end else begin
        err_n = 1'b1; // truncation
      end
      err_n = err_n | in_err;
      crc_n = crc_q | in_crc;
      if (in_last) begin
        done_o   = 1'b1;
        done_len = room ? cnt_q + 1'b1 : cnt_q;
        done_err = err_n;
        done_crc = crc_n;
        cnt_n    = '0;
        err_n    = 1'b0;
        crc_n    = 1'b0;
      end
    end
    if (lose) begin
      ovf_n  = ovf_q + 1'b1;
      skip_n = ~in_last;
    end
    wr_addr = cnt_q[LEN_W-1:2];
    wr_word = word_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      word_q <= '0;
      err_q  <= 1'b0;
      crc_q  <= 1'b0;
      skip_q <= 1'b0;
      ovf_q  <= '0;
    end else if (in_vld) begin
      cnt_q  <= cnt_n;
      word_q <= word_n;
      err_q  <= err_n;
      crc_q  <= crc_n;
      skip_q <= skip_n;
      ovf_q  <= ovf_n;
    end
  end

  assign ovf_cnt = ovf_q;
endmodule

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int unsigned AW = 9,
  localparam int unsigned WORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxb_irq.sv
module rxb_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic en_we,
  input  logic en_d,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o,
  output logic pend_o,
  output logic irq_o
);
  logic en_q, en_n, pend_q, pend_n;

  always_comb begin
    en_n   = en_we ? en_d : en_q;
    pend_n = set_i ? 1'b1 : (clr_i ? 1'b0 : pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_n;
      pend_q <= pend_n;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = en_q & pend_q;
endmodule

// File: rtl/mgmt_rx_buffer.sv
module mgmt_rx_buffer
  import mgmt_rx_pkg::*;
#(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned OVF_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_byte_vld,
  input  logic [7:0]         rx_byte,
  input  logic               rx_byte_last,
  input  logic               rx_bad,
  input  logic               rx_fcs_bad,
  input  logic               host_req,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  output logic               rx_irq
);
  localparam int unsigned WA_W  = LEN_W - 2;
  localparam int unsigned CNT_W = LEN_W - 1;

  logic             st_rdy, st_rdy_n, st_err, st_err_n, st_crc, st_crc_n;
  logic [LEN_W-1:0] st_len, st_len_n;
  logic [CNT_W-1:0] rd_ptr, rd_ptr_n, words_total;
  logic [LEN_W:0]   len_plus;
  logic [31:0]      rdata_q, rdata_n, mem_rdata, ctrl_word, mem_wdata;
  logic             mem_we, fill_done, done_err, done_crc;
  logic [WA_W-1:0]  mem_waddr;
  logic [LEN_W-1:0] done_len;
  logic [OVF_W-1:0] ovf_cnt;
  logic             hit_ctl, hit_dat, hit_ien, hit_cause, ack, dat_rd, have_word;
  logic             ien_q, cause_q;
  logic             unused_wdata;

  assign unused_wdata = ^{host_wdata[31:16], host_wdata[14:1]};

  rxb_fill #(.LEN_W(LEN_W), .OVF_W(OVF_W)) u_fill (
    .clk(clk), .rst_n(rst_n),
    .in_vld(rx_byte_vld), .in_byte(rx_byte), .in_last(rx_byte_last),
    .in_err(rx_bad), .in_crc(rx_fcs_bad), .hold_i(st_rdy),
    .wr_en(mem_we), .wr_addr(mem_waddr), .wr_word(mem_wdata),
    .done_o(fill_done), .done_len(done_len), .done_err(done_err),
    .done_crc(done_crc), .ovf_cnt(ovf_cnt)
  );

  rxb_store #(.AW(WA_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_ptr[WA_W-1:0]), .rdata(mem_rdata)
  );

  rxb_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .en_we(hit_ien & host_wr), .en_d(host_wdata[IRQ_RX]),
    .set_i(fill_done), .clr_i(ack),
    .en_o(ien_q), .pend_o(cause_q), .irq_o(rx_irq)
  );

  always_comb begin
    hit_ctl   = host_req & (host_addr == OFS_RXCTL);
    hit_dat   = host_req & (host_addr == OFS_RXDAT);
    hit_ien   = host_req & (host_addr == OFS_IEN);
    hit_cause = host_req & (host_addr == OFS_ICAUSE);
    ack       = hit_ctl & host_wr & ~host_wdata[BIT_RDY];
    dat_rd    = hit_dat & ~host_wr;
    len_plus    = {1'b0, st_len} + (LEN_W+1)'(3);
    words_total = len_plus[LEN_W:2];
    have_word   = st_rdy & (rd_ptr < words_total);

    ctrl_word = '0;
    ctrl_word[BIT_RDY]     = st_rdy;
    ctrl_word[BIT_ERR]     = st_err;
    ctrl_word[BIT_CRC]     = st_crc;
    ctrl_word[LEN_W-1:0]   = st_len;

    st_rdy_n = st_rdy;
    st_err_n = st_err;
    st_crc_n = st_crc;
    st_len_n = st_len;
    rd_ptr_n = rd_ptr;
    if (fill_done) begin
      st_rdy_n = 1'b1;
      st_err_n = done_err;
      st_crc_n = done_crc;
      st_len_n = done_len;
      rd_ptr_n = '0;
    end else if (ack) begin
      st_rdy_n = 1'b0;
      st_err_n = 1'b0;
      st_crc_n = 1'b0;
      st_len_n = '0;
      rd_ptr_n = '0;
    end else if (dat_rd && have_word) begin
      rd_ptr_n = rd_ptr + 1'b1;
    end

    rdata_n = '0;
    if (hit_ctl)   rdata_n = ctrl_word;
    if (hit_dat)   rdata_n = have_word ? mem_rdata : '0;
    if (hit_ien)   rdata_n[IRQ_RX] = ien_q;
    if (hit_cause) rdata_n[IRQ_RX] = cause_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_rdy  <= 1'b0;
      st_err  <= 1'b0;
      st_crc  <= 1'b0;
      st_len  <= '0;
      rd_ptr  <= '0;
      rdata_q <= '0;
    end else begin
      st_rdy <= st_rdy_n;
      st_err <= st_err_n;
      st_crc <= st_crc_n;
      st_len <= st_len_n;
      rd_ptr <= rd_ptr_n;
      if (host_req && !host_wr) rdata_q <= rdata_n;
    end
  end

  assign host_rdata = rdata_q;
endmodule

// File: rtl/mgmt_rx_chk.sv
module mgmt_rx_chk #(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned OVF_W = 16,
  localparam int unsigned CNT_W = LEN_W - 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_byte_vld,
  input logic             st_rdy,
  input logic [LEN_W-1:0] st_len,
  input logic             ack,
  input logic             fill_done,
  input logic             mem_we,
  input logic [CNT_W-1:0] rd_ptr,
  input logic [CNT_W-1:0] words_total,
  input logic [OVF_W-1:0] ovf_cnt,
  input logic             rx_irq
);
  assert_ready_from_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_rdy) |-> $past(fill_done));

  assert_ready_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rdy && !ack) |=> st_rdy);

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !fill_done) |=> (!st_rdy && st_len == '0));

  assert_no_write_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !st_rdy);

  assert_drop_counted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_byte_vld && st_rdy) |=> (ovf_cnt == OVF_W'($past(ovf_cnt) + 1'b1)));

  assert_ptr_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= words_total);

  assert_irq_needs_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> st_rdy);
endmodule

bind mgmt_rx_buffer mgmt_rx_chk #(.LEN_W(LEN_W), .OVF_W(OVF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_byte_vld(rx_byte_vld),
  .st_rdy(st_rdy), .st_len(st_len), .ack(ack), .fill_done(fill_done),
  .mem_we(mem_we), .rd_ptr(rd_ptr), .words_total(words_total),
  .ovf_cnt(ovf_cnt), .rx_irq(rx_irq)
);

// File: tb/test_mgmt_rx_buffer.sv
module test_mgmt_rx_buffer;
  localparam logic [11:0] A_CTL = 12'h810, A_DAT = 12'h818;
  localparam logic [11:0] A_IEN = 12'h8C0, A_CAU = 12'h8C4;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_byte_vld, rx_byte_last, rx_bad, rx_fcs_bad;
  logic [7:0] rx_byte;
  logic host_req, host_wr;
  logic [11:0] host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic rx_irq;

  int checks = 0;
  int failures = 0;
  bit done_flag = 0;
  logic [7:0] fb [0:2099];

  always #2 clk = ~clk; // 250 MHz

  mgmt_rx_buffer i_mgmt_rx_buffer (
    .clk(clk), .rst_n(rst_n), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
    .rx_byte_last(rx_byte_last), .rx_bad(rx_bad), .rx_fcs_bad(rx_fcs_bad),
    .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] exp_word(input int w, input int len);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (4*w + k < len) r[31-8*k -: 8] = fb[4*w + k];
    return r;
  endfunction

  task automatic host_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); host_req = 1; host_wr = 0; host_addr = a;
    @(negedge clk); host_req = 0; d = host_rdata;
  endtask

  task automatic host_wrt(input logic [11:0] a, input logic [31:0] v);
    @(negedge clk); host_req = 1; host_wr = 1; host_addr = a; host_wdata = v;
    @(negedge clk); host_req = 0; host_wr = 0;
  endtask

  task automatic send(input int n, input int err_at, input bit crc, input int ack_at, input bit rec);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      @(negedge clk);
      b = 8'($urandom);
      if (rec) fb[i] = b;
      rx_byte_vld = 1; rx_byte = b; rx_byte_last = (i == n-1);
      rx_bad = (i == err_at); rx_fcs_bad = crc && (i == n-1);
      host_req = (i == ack_at); host_wr = 1; host_addr = A_CTL; host_wdata = 0;
    end
    @(negedge clk);
    rx_byte_vld = 0; rx_byte_last = 0; rx_bad = 0; rx_fcs_bad = 0;
    host_req = 0; host_wr = 0;
  endtask

  task automatic check_frame(input int n, input bit e, input bit c, input bit irq_exp);
    logic [31:0] d;
    host_rd(A_CTL, d);
    chk("R2 control word", d, {16'h0, 1'b1, e, c, 2'b00, 11'(n)});
    host_rd(A_CAU, d);
    chk("R9 cause pending", d, 32'h1);
    chk("R9 irq level", {31'h0, rx_irq}, {31'h0, irq_exp});
    for (int w = 0; w < (n+3)/4; w++) begin
      host_rd(A_DAT, d);
      chk("R3 data word", d, exp_word(w, n));
    end
    host_rd(A_DAT, d);
    chk("R4 read past end", d, 32'h0);
  endtask

  task automatic do_ack();
    logic [31:0] d;
    host_wrt(A_CTL, 32'h0);
    host_rd(A_CTL, d);  chk("R6 control cleared", d, 32'h0);
    host_rd(A_CAU, d);  chk("R6 cause cleared", d, 32'h0);
    chk("R6 irq low", {31'h0, rx_irq}, 32'h0);
    host_rd(A_DAT, d);  chk("R4 data when empty", d, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int dl [8] = '{1, 2, 3, 4, 5, 7, 8, 64};
    void'($urandom(32'h1234_5678));
    rst_n = 0; rx_byte_vld = 0; rx_byte = 0; rx_byte_last = 0; rx_bad = 0;
    rx_fcs_bad = 0; host_req = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 irq after reset", {31'h0, rx_irq}, 32'h0);
    host_rd(A_CTL, d); chk("R1 control after reset", d, 32'h0);
    host_rd(A_IEN, d); chk("R1 enable after reset", d, 32'h0);
    host_rd(A_CAU, d); chk("R1 cause after reset", d, 32'h0);
    host_rd(A_DAT, d); chk("R4 data before any frame", d, 32'h0);

    // R9 enable register, transmit bit reads zero
    host_wrt(A_IEN, 32'h3);
    host_rd(A_IEN, d); chk("R9 enable readback", d, 32'h1);

    // R10 unmapped offset
    host_rd(12'h814, d); chk("R10 unmapped read", d, 32'h0);

    // directed lengths then random ones
    for (int f = 0; f < 18; f++) begin
      int n, ea;
      bit e, c, en;
      n  = (f < 8) ? dl[f] : int'($urandom_range(1, 200));
      e  = (f >= 8) && ($urandom_range(0, 2) == 0);
      c  = (f >= 8) && ($urandom_range(0, 2) == 0);
      ea = e ? int'($urandom_range(0, n-1)) : -1;
      en = (f != 3);
      if (!en) host_wrt(A_IEN, 32'h0);
      send(n, ea, c, -1, 1);
      check_frame(n, e, c, en); // R5 flags on error frames
      host_wrt(A_CTL, 32'h0000_8000);
      host_rd(A_CTL, d); chk("R6 ignored control write", d, {16'h0, 1'b1, e, c, 2'b00, 11'(n)});
      do_ack();
      if (!en) host_wrt(A_IEN, 32'h1);
    end

    // R7 overflow: held frame stays intact
    send(20, -1, 0, -1, 1);
    send(30, 5, 1, -1, 0);
    check_frame(20, 0, 0, 1);
    do_ack();

    // R7 acknowledgement arriving mid-frame: rest of that frame still dropped
    send(12, -1, 0, -1, 1);
    send(16, -1, 0, 5, 0);
    host_rd(A_CTL, d); chk("R7 tail of dropped frame discarded", d, 32'h0);
    host_rd(A_CAU, d); chk("R7 no cause from dropped frame", d, 32'h0);
    send(9, -1, 0, -1, 1);
    check_frame(9, 0, 0, 1);
    do_ack();

    // R8 truncation of an oversize frame
    send(2050, -1, 0, -1, 1);
    check_frame(2047, 1, 0, 1);
    do_ack();

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule